// File: doc/BRIEF.md
# Point Display Handshake Controller

This controller paces the flow of coordinate triplets from a host computer into a random-scan display path, one triplet at a time. When the host raises its ready line, the triplet is captured in a holding rank. On the next cycle it is copied into an output rank, which feeds the converters. Only the output rank drives the converters, so they never see the input word while it is changing. A fixed settling interval follows, sized so the beam deflectors finish moving. The beam intensity is then enabled for a short dwell, and after that the host is asked for the next point.

The display datapath reports whether the transformed point falls outside the visible window. That flag is read once, at the end of the settling interval. A point outside the window is dropped: the beam stays dark and the next point is requested at once. The controller also turns each rising edge of a frame timing source into a one-cycle frame pulse. When cursor display is wanted, it inserts one cursor slot per frame in place of a host point. During that slot the multiplexer select routes the cursor position onto the display path.

Top module: `point_sequencer`

## Requirements
- R1: A triplet is accepted (`ld_lo` high for that cycle) only in an idle cycle with `host_rdy` high, no cursor slot pending, and `host_rdy` having been low at least once since the previous acceptance. A host that holds `host_rdy` high gets exactly one acceptance.
- R2: The holding rank captures `trip_in` in the acceptance cycle. `ld_hi` is high in the next cycle only, and at the end of that cycle the holding rank is copied into `rank_hi`. `rank_hi` does not change in any other cycle.
- R3: For a host point that is inside the window, `beam_on` first goes high exactly SETTLE_CYC+1 cycles after the `ld_hi` cycle and stays high for exactly DWELL_CYC cycles.
- R4: After a lit host point, `nxt_req` is high for exactly one cycle, the cycle right after the last `beam_on` cycle. It is never high together with `beam_on`.
- R5: `out_of_win` is sampled only in the cycle SETTLE_CYC cycles after `ld_hi`. If it is high there, `beam_on` stays low and `nxt_req` pulses in the next cycle. Its value in any other cycle has no effect.
- R6: Coordinate i of a triplet occupies bits [i*W +: W] (x is i=0, y is i=1, z is i=2), and its MSB is the sign. `neg_ref[i]` equals the MSB of coordinate i in `rank_hi`. A value of 1 selects the negative reference and 0 selects the positive reference.
- R7: `frame_pls` is high for exactly one cycle, the cycle after each cycle in which `frame_tick` is high following a low cycle.
- R8: A `frame_tick` rising edge seen while `cur_req` is high queues one cursor slot. Without `cur_req`, no slot is queued. An idle controller serves a queued slot ahead of a waiting host: `cur_sel` is high for SETTLE_CYC+DWELL_CYC consecutive cycles starting the cycle after the idle cycle, `beam_on` is high during the last DWELL_CYC of those cycles, and neither load strobe nor `nxt_req` is asserted during the slot.
- R9: During and right after reset, all strobes, `beam_on`, `nxt_req`, `cur_sel`, `frame_pls`, `rank_hi` and `neg_ref` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rdy | input | 1 | Host has a triplet available |
| trip_in | input | 3*W | Triplet from host, x in the low field |
| out_of_win | input | 1 | Transformed point lies outside the display window |
| cur_req | input | 1 | Cursor display wanted |
| frame_tick | input | 1 | Frame timing source |
| ld_lo | output | 1 | Holding rank load strobe |
| ld_hi | output | 1 | Output rank load strobe |
| rank_hi | output | 3*W | Output rank contents feeding the converters |
| neg_ref | output | 3 | Per-coordinate reference polarity select |
| beam_on | output | 1 | Intensity enable |
| nxt_req | output | 1 | Request for the next point |
| cur_sel | output | 1 | Cursor multiplexer select |
| frame_pls | output | 1 | One-cycle frame pulse |

## Verification
The hardest case to reach is a window flag that changes while the deflectors are still settling. One variant holds the flag high until the last settling cycle and then drops it, so the point must be lit. Another raises the flag only in that last cycle, so the point must be skipped. The bench takes the `ld_hi` cycle seen at the ports as its reference and times each flag edge from it. A second hard case is a host waiting while a cursor slot is pending. For this the bench raises `frame_tick` and then `host_rdy` on the next cycle, so the queued slot must win and the host point must follow straight after it.

// File: rtl/point_sequencer.sv
module point_sequencer #(
  parameter int W          = 10,
  parameter int SETTLE_CYC = 350,
  parameter int DWELL_CYC  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_rdy,
  input  logic [3*W-1:0] trip_in,
  input  logic           out_of_win,
  input  logic           cur_req,
  input  logic           frame_tick,
  output logic           ld_lo,
  output logic           ld_hi,
  output logic [3*W-1:0] rank_hi,
  output logic [2:0]     neg_ref,
  output logic           beam_on,
  output logic           nxt_req,
  output logic           cur_sel,
  output logic           frame_pls
);
  localparam int MAXC = (SETTLE_CYC > DWELL_CYC) ? SETTLE_CYC : DWELL_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SETTLE, S_DWELL, S_REQ} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [3*W-1:0] rank_lo;
  logic           armed, pend, tick_d;
  logic           start_cur, tick_rise;

  assign tick_rise = frame_tick & ~tick_d;
  assign start_cur = (st == S_IDLE) && pend;
  assign ld_lo     = (st == S_IDLE) && !pend && host_rdy && armed;
  assign ld_hi     = (st == S_LOAD);
  assign beam_on   = (st == S_DWELL);
  assign nxt_req   = (st == S_REQ);

  for (genvar g = 0; g < 3; g++) begin : g_sign
    assign neg_ref[g] = rank_hi[g*W + W - 1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      rank_lo   <= '0;
      rank_hi   <= '0;
      armed     <= 1'b1;
      pend      <= 1'b0;
      tick_d    <= 1'b0;
      frame_pls <= 1'b0;
      cur_sel   <= 1'b0;
    end else begin
      tick_d    <= frame_tick;
      frame_pls <= tick_rise;
      pend      <= (pend & ~start_cur) | (tick_rise & cur_req);
      if (ld_lo)          armed <= 1'b0;
      else if (!host_rdy) armed <= 1'b1;
      if (ld_lo) rank_lo <= trip_in;
      if (ld_hi) rank_hi <= rank_lo;
      case (st)
        S_IDLE: begin
          if (start_cur) begin
            cur_sel <= 1'b1;
            st      <= S_SETTLE;
            cnt     <= CW'(SETTLE_CYC - 1);
          end else if (ld_lo) begin
            st <= S_LOAD;
          end
        end
        S_LOAD: begin
          st  <= S_SETTLE;
          cnt <= CW'(SETTLE_CYC - 1);
        end
        S_SETTLE: begin
          if (cnt == '0) begin
            if (!cur_sel && out_of_win) begin
              st <= S_REQ;
            end else begin
              st  <= S_DWELL;
              cnt <= CW'(DWELL_CYC - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_DWELL: begin
          if (cnt == '0) begin
            if (cur_sel) begin
              cur_sel <= 1'b0;
              st      <= S_IDLE;
            end else begin
              st <= S_REQ;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_REQ:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module point_sequencer_chk #(
  parameter int SETTLE_CYC = 350
) (
  input logic clk,
  input logic rst_n,
  input logic host_rdy,
  input logic ld_lo,
  input logic ld_hi,
  input logic beam_on,
  input logic nxt_req,
  input logic cur_sel,
  input logic frame_pls
);
  int since_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)                 since_hi <= 0;
    else if (ld_hi)             since_hi <= 0;
    else if (since_hi < 32'h7fff_ffff) since_hi <= since_hi + 1;
  end

  assert_accept_needs_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |-> host_rdy);
  assert_upper_follows_lower_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> ld_hi);
  assert_settle_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(beam_on) && !cur_sel) |-> since_hi == SETTLE_CYC);
  assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_req |=> !nxt_req);
  assert_req_not_lit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(nxt_req && beam_on));
  assert_frame_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pls |=> !frame_pls);
  assert_cursor_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_sel |-> !(ld_lo || ld_hi || nxt_req));
endmodule

bind point_sequencer point_sequencer_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rdy(host_rdy), .ld_lo(ld_lo), .ld_hi(ld_hi),
  .beam_on(beam_on), .nxt_req(nxt_req), .cur_sel(cur_sel), .frame_pls(frame_pls)
);

// File: tb/point_sequencer_test.sv
module point_sequencer_test;
  localparam int W = 4;
  localparam int S = 5;
  localparam int D = 3;

  logic clk = 0, rst_n = 0, host_rdy = 0, out_of_win = 0, cur_req = 0, frame_tick = 0;
  logic [3*W-1:0] trip_in = '0;
  logic ld_lo, ld_hi, beam_on, nxt_req, cur_sel, frame_pls;
  logic [3*W-1:0] rank_hi;
  logic [2:0] neg_ref;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  point_sequencer #(.W(W), .SETTLE_CYC(S), .DWELL_CYC(D)) uut (
    .clk(clk), .rst_n(rst_n), .host_rdy(host_rdy), .trip_in(trip_in),
    .out_of_win(out_of_win), .cur_req(cur_req), .frame_tick(frame_tick),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .rank_hi(rank_hi), .neg_ref(neg_ref),
    .beam_on(beam_on), .nxt_req(nxt_req), .cur_sel(cur_sel), .frame_pls(frame_pls));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic oow_for(input int mode, input int rel);
    case (mode)
      1: return 1'b1;
      2: return rel < S;
      3: return rel == S;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_point(input logic [3*W-1:0] v, input int mode);
    int a = -1, h = -1, bf = -1, bc = 0, rq = -1, rc = 0, extra = 0, hi_bad = 0;
    logic [3*W-1:0] old = rank_hi;
    bit lit = !(mode == 1 || mode == 3);
    for (int i = 0; i < S + D + 8; i++) begin
      @(posedge clk); #5;
      host_rdy = 1; trip_in = v;
      out_of_win = oow_for(mode, (h >= 0) ? i - h : -1);
      #5;
      if (ld_lo) begin if (a < 0) a = i; else extra++; end
      if (ld_hi && h < 0) h = i;
      if (a >= 0 && h < 0 && rank_hi !== old) hi_bad++;
      if (beam_on) begin if (bf < 0) bf = i; bc++; end
      if (nxt_req) begin if (rq < 0) rq = i; rc++; end
    end
    chk(a == 0, "R1", "accept cycle", a, 0);
    chk(extra == 0, "R1", "re-accept while ready held", extra, 0);
    chk(h == a + 1, "R2", "upper strobe cycle", h, a + 1);
    chk(hi_bad == 0, "R2", "upper rank moved early", hi_bad, 0);
    chk(rank_hi === v, "R2", "upper rank value", int'(rank_hi), int'(v));
    chk(neg_ref === {v[3*W-1], v[2*W-1], v[W-1]}, "R6", "sign selects",
        int'(neg_ref), int'({v[3*W-1], v[2*W-1], v[W-1]}));
    if (lit) begin
      chk(bf == h + S + 1, "R3", "intensity start", bf, h + S + 1);
      chk(bc == D, "R3", "dwell length", bc, D);
      chk(rq == h + S + D + 1, "R4", "request cycle", rq, h + S + D + 1);
    end else begin
      chk(bc == 0, "R5", "skipped point lit", bc, 0);
      chk(rq == h + S + 1, "R5", "skip request cycle", rq, h + S + 1);
    end
    chk(rc == 1, "R4", "request pulse count", rc, 1);
    @(posedge clk); #5; host_rdy = 0; out_of_win = 0;
    @(posedge clk);
  endtask

  task automatic run_cursor(input bit want);
    int fp = -1, fc = 0, cf = -1, cc = 0, cb = 0, lf = -1, rc = 0, cq = 0;
    for (int i = 0; i < 2 * (S + D) + 14; i++) begin
      @(posedge clk); #5;
      frame_tick = (i == 0); cur_req = want; host_rdy = (i >= 1);
      trip_in = 12'h5a3;
      #5;
      if (frame_pls) begin if (fp < 0) fp = i; fc++; end
      if (cur_sel) begin
        if (cf < 0) cf = i;
        cc++;
        if (beam_on) cb++;
        if (nxt_req || ld_lo || ld_hi) cq++;
      end
      if (ld_lo && lf < 0) lf = i;
      if (nxt_req) rc++;
    end
    chk(fp == 1 && fc == 1, "R7", "frame pulse cycle", fp, 1);
    if (want) begin
      chk(cf == 2, "R8", "cursor slot start", cf, 2);
      chk(cc == S + D, "R8", "cursor slot length", cc, S + D);
      chk(cb == D, "R8", "cursor intensity", cb, D);
      chk(cq == 0, "R8", "strobes in cursor slot", cq, 0);
      chk(lf == 2 + S + D, "R8", "host after cursor", lf, 2 + S + D);
    end else begin
      chk(cc == 0, "R8", "no slot without request", cc, 0);
      chk(lf == 1, "R8", "host served directly", lf, 1);
    end
    chk(rc == 1, "R8", "requests for host only", rc, 1);
    @(posedge clk); #5; host_rdy = 0; cur_req = 0;
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk({ld_lo, ld_hi, beam_on, nxt_req, cur_sel, frame_pls} == 6'b0, "R9", "strobes in reset",
        int'({ld_lo, ld_hi, beam_on, nxt_req, cur_sel, frame_pls}), 0);
    chk(rank_hi == '0 && neg_ref == 3'b0, "R9", "rank in reset", int'(rank_hi), 0);
    @(posedge clk); #5; rst_n = 1;
    @(posedge clk); #5;
    chk({ld_hi, beam_on, nxt_req, cur_sel, frame_pls} == 5'b0, "R9", "outputs after reset",
        int'({ld_hi, beam_on, nxt_req, cur_sel, frame_pls}), 0);
    for (int k = 0; k < 32; k++) begin
      logic [3*W-1:0] v;
      v = 12'(k * 397 + 12'h111 * (k % 3)) ^ {k[2], 3'b0, k[1], 3'b0, k[0], 3'b0};
      run_point(v, k % 4);
    end
    run_cursor(1'b1);
    run_cursor(1'b0);
    run_point(12'h888, 2);
    run_point(12'h777, 3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule